// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts hardware activity for a processor core. It has one cycle counter and two event counters, all 32 bits wide. Each event counter picks one line from a 256-wide vector of per-clock event strobes, using an 8-bit selector held in a single control word. Software reaches the control word and the three count values through a simple register port. The port has a write strobe, a 2-bit address, write data, and read data that follows the address in the same cycle.

No counter can be switched off on its own. One master enable gates all three counters. To park an event counter, software points its selector at an idle code that never counts. Each counter sets its own sticky overflow flag when it wraps. Software clears a flag by writing a 1 to that bit, so the control word read back can be written back whole to acknowledge an interrupt. A single interrupt line combines the flags, each one gated by its own enable bit.

Register addresses: 0 holds the control word, 1 the cycle count, 2 event counter 0 and 3 event counter 1.

Top module: `perf_mon3`

## Requirements
- R1: After reset all four registers read 0 and `irq_out` is 0.
- R2: Control bit 0 is the single enable. While it is 0, no counter changes except through a direct write or a reset bit.
- R3: While enabled, an event counter adds 1 on each clock where its selected strobe is high. Selector code 0xFF counts every clock, code 0x20 never counts, and any other code N follows `evt_strobe[N]`. Counter 0 is selected by control bits 27:20 and counter 1 by bits 19:12.
- R4: Writing the control word with bit 1 set zeroes both event counters. Writing it with bit 2 set zeroes the cycle counter and its divider. Bits 1 and 2 always read back as 0.
- R5: A write to a count register loads the written value. In that cycle the write wins over any increment of the same counter.
- R6: While enabled with control bit 3 at 0, the cycle counter adds 1 every clock.
- R7: With control bit 3 at 1, the cycle counter adds 1 once per 64 enabled clocks. The divider runs on every enabled clock and is cleared by the cycle reset bit.
- R8: A step from 0xFFFFFFFF to 0 sets that counter's overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R9: Writing 1 to an overflow flag bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R10: `irq_out` is 1 exactly when some overflow flag is set and its interrupt enable is 1. Enable bit 4 pairs with flag bit 8, bit 5 with flag bit 9, and bit 6 with flag bit 10.
- R11: The control word reads back the enable (bit 0), divide (bit 3), interrupt enables (bits 6:4), flags (bits 10:8) and both selectors. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| evt_strobe | input | 256 | Per-clock event strobes, indexed by selector code |
| irq_out | output | 1 | Combined overflow interrupt |

## Verification
Selectors are first steered at sparse, dense and idle strobe patterns. This separates indexing by selector from the special codes 0xFF and 0x20, and shows that the two selector fields are not swapped. Counters are preloaded just below the wrap point, so each flag, its bit position and its interrupt pairing are seen one at a time. Clears are also issued in the same cycle as wraps. A long divided run catches a divider that is off by one. A final random phase mixes control writes, count writes and strobes. Against the cycle reference model, it exposes mistakes in priority and timing between writes, resets and increments.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W    = 32;
  localparam int SEL_W    = 8;
  localparam int NUM_EVT  = 1 << SEL_W;
  localparam int DIV_LOG2 = 6;
  localparam int NUM_CTR  = 3;   // index 0: event 0, 1: event 1, 2: cycle

  localparam logic [SEL_W-1:0] CODE_IDLE  = 8'h20;
  localparam logic [SEL_W-1:0] CODE_CYCLE = 8'hFF;

  // control word bit positions
  localparam int B_EN     = 0;
  localparam int B_RST_EV = 1;
  localparam int B_RST_CY = 2;
  localparam int B_DIV    = 3;
  localparam int B_IEN    = 4;   // 3 bits
  localparam int B_OVF    = 8;   // 3 bits
  localparam int B_SEL1   = 12;  // 8 bits
  localparam int B_SEL0   = 20;  // 8 bits

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CYC = 2'd1;
  localparam logic [1:0] A_EV0 = 2'd2;
  localparam logic [1:0] A_EV1 = 2'd3;

  typedef struct packed {
    logic                   en;
    logic                   div;
    logic [NUM_CTR-1:0]     ien;
    logic [SEL_W-1:0]       sel0;
    logic [SEL_W-1:0]       sel1;
  } ctl_t;
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctl,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [NUM_CTR-1:0] ovf_set,
  output ctl_t               ctl,
  output logic [NUM_CTR-1:0] ovf,
  output logic               clr_ev,
  output logic               clr_cyc
);
  ctl_t               ctl_nxt;
  logic [NUM_CTR-1:0] ovf_nxt;
  logic [NUM_CTR-1:0] clr_mask;
  logic               ovf_en;

  always_comb begin
    ctl_nxt.en   = wdata[B_EN];
    ctl_nxt.div  = wdata[B_DIV];
    ctl_nxt.ien  = wdata[B_IEN +: NUM_CTR];
    ctl_nxt.sel0 = wdata[B_SEL0 +: SEL_W];
    ctl_nxt.sel1 = wdata[B_SEL1 +: SEL_W];
    clr_mask     = wr_ctl ? wdata[B_OVF +: NUM_CTR] : '0;
    ovf_nxt      = (ovf & ~clr_mask) | ovf_set;
    ovf_en       = wr_ctl | (|ovf_set);
    clr_ev       = wr_ctl & wdata[B_RST_EV];
    clr_cyc      = wr_ctl & wdata[B_RST_CY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (wr_ctl) ctl <= ctl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf <= '0;
    else if (ovf_en) ovf <= ovf_nxt;
  end

  // a set flag survives unless a 1 is written to its bit
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf & $past(ovf & ~clr_mask)) == $past(ovf & ~clr_mask)));
  // a wrap pulse always leaves its flag set
  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_set) |=> ((ovf & $past(ovf_set)) == $past(ovf_set)));
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] strobes,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               clr,
  output logic [CNT_W-1:0]   count,
  output logic               wrap
);
  logic             hit;
  logic             inc;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (sel == CODE_IDLE)       hit = 1'b0;
    else if (sel == CODE_CYCLE) hit = 1'b1;
    else                        hit = strobes[sel];
    inc     = enable & hit;
    cnt_nxt = count;
    wrap    = 1'b0;
    if (load)     cnt_nxt = load_val;
    else if (clr) cnt_nxt = '0;
    else if (inc) begin
      cnt_nxt = count + 1'b1;
      wrap    = &count;
    end
    cnt_en = load | clr | inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_nxt;
  end

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && !enable) |=> $stable(count));
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && enable && hit) |=> (count == $past(count) + 1'b1));
  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && sel == CODE_IDLE) |=> $stable(count));
  assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
  import pmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             div,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [DIV_LOG2-1:0] pre;
  logic [DIV_LOG2-1:0] pre_nxt;
  logic                pre_en;
  logic                tick;
  logic                cnt_en;
  logic [CNT_W-1:0]    cnt_nxt;

  always_comb begin
    pre_en  = clr | enable;
    pre_nxt = clr ? '0 : pre + 1'b1;
    tick    = enable & (~div | (&pre));
    cnt_nxt = count;
    wrap    = 1'b0;
    if (load)      cnt_nxt = load_val;
    else if (clr)  cnt_nxt = '0;
    else if (tick) begin
      cnt_nxt = count + 1'b1;
      wrap    = &count;
    end
    cnt_en = load | clr | tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre <= '0;
    else if (pre_en) pre <= pre_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_nxt;
  end

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> (count == '0));
  assert_plain_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !div && !load && !clr) |=> (count == $past(count) + 1'b1));
  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div && !(&pre) && !load && !clr) |=> $stable(count));
endmodule

// File: rtl/perf_mon3.sv
module perf_mon3
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               irq_out
);
  ctl_t               ctl;
  logic [NUM_CTR-1:0] ovf;
  logic [NUM_CTR-1:0] wrap;
  logic               clr_ev;
  logic               clr_cyc;
  logic               wr_ctl;
  logic [CNT_W-1:0]   cnt [NUM_CTR];
  logic [CNT_W-1:0]   ctl_word;
  logic               wdata_unused;

  assign wr_ctl       = reg_wr & (reg_addr == A_CTL);
  assign wdata_unused = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

  pmu_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctl  (wr_ctl),
    .wdata   (reg_wdata),
    .ovf_set (wrap),
    .ctl     (ctl),
    .ovf     (ovf),
    .clr_ev  (clr_ev),
    .clr_cyc (clr_cyc)
  );

  for (genvar g = 0; g < 2; g++) begin : g_evt
    logic [SEL_W-1:0] sel_g;
    assign sel_g = (g == 0) ? ctl.sel0 : ctl.sel1;
    pmu_event_counter u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctl.en),
      .sel      (sel_g),
      .strobes  (evt_strobe),
      .load     (reg_wr && (reg_addr == A_EV0 + 2'(g))),
      .load_val (reg_wdata),
      .clr      (clr_ev),
      .count    (cnt[g]),
      .wrap     (wrap[g])
    );
  end

  pmu_cycle_counter u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ctl.en),
    .div      (ctl.div),
    .load     (reg_wr && (reg_addr == A_CYC)),
    .load_val (reg_wdata),
    .clr      (clr_cyc),
    .count    (cnt[2]),
    .wrap     (wrap[2])
  );

  always_comb begin
    ctl_word                        = '0;
    ctl_word[B_EN]                  = ctl.en;
    ctl_word[B_DIV]                 = ctl.div;
    ctl_word[B_IEN +: NUM_CTR]      = ctl.ien;
    ctl_word[B_OVF +: NUM_CTR]      = ovf;
    ctl_word[B_SEL0 +: SEL_W]       = ctl.sel0;
    ctl_word[B_SEL1 +: SEL_W]       = ctl.sel1;
    unique case (reg_addr)
      A_CTL:   reg_rdata = ctl_word;
      A_CYC:   reg_rdata = cnt[2];
      A_EV0:   reg_rdata = cnt[0];
      default: reg_rdata = cnt[1];
    endcase
  end

  assign irq_out = |(ovf & ctl.ien);

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|ovf));
  assert_rst_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTL) |-> (reg_rdata[B_RST_CY:B_RST_EV] == 2'b00));
endmodule

// File: tb/perf_mon3_bench.sv
module perf_mon3_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic [255:0] evt_strobe = '0;
  logic         irq_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  int unsigned m_cnt [3];   // 0 ev0, 1 ev1, 2 cycle
  int unsigned m_pre;
  bit          m_en, m_div;
  bit [2:0]    m_ien, m_ovf;
  bit [7:0]    m_sel0, m_sel1;

  perf_mon3 u_perf_mon3 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_strobe(evt_strobe), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  function automatic bit m_hit(bit [7:0] s);
    if (s == 8'h20) return 1'b0;
    if (s == 8'hFF) return 1'b1;
    return evt_strobe[s];
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    logic [31:0] w;
    w = '0;
    w[0] = m_en; w[3] = m_div; w[6:4] = m_ien; w[10:8] = m_ovf;
    w[27:20] = m_sel0; w[19:12] = m_sel1;
    case (a)
      2'd0: return w;
      2'd1: return m_cnt[2];
      2'd2: return m_cnt[0];
      default: return m_cnt[1];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_cnt[2] = 0; m_pre = 0;
      m_en = 0; m_div = 0; m_ien = 0; m_ovf = 0; m_sel0 = 0; m_sel1 = 0;
    end else begin
      bit       wc;
      bit [2:0] setf;
      bit [7:0] sels [2];
      bit       tick;
      wc = reg_wr && reg_addr == 2'd0;
      setf = 0;
      sels[0] = m_sel0; sels[1] = m_sel1;
      for (int i = 0; i < 2; i++) begin
        if (reg_wr && reg_addr == 2'(2 + i)) m_cnt[i] = reg_wdata;
        else if (wc && reg_wdata[1]) m_cnt[i] = 0;
        else if (m_en && m_hit(sels[i])) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) setf[i] = 1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      tick = m_en && (!m_div || m_pre == 63);
      if (wc && reg_wdata[2]) m_pre = 0;
      else if (m_en) m_pre = (m_pre + 1) % 64;
      if (reg_wr && reg_addr == 2'd1) m_cnt[2] = reg_wdata;
      else if (wc && reg_wdata[2]) m_cnt[2] = 0;
      else if (tick) begin
        if (m_cnt[2] == 32'hFFFF_FFFF) setf[2] = 1;
        m_cnt[2] = m_cnt[2] + 1;
      end
      m_ovf = (m_ovf & ~(wc ? reg_wdata[10:8] : 3'b000)) | setf;
      if (wc) begin
        m_en = reg_wdata[0]; m_div = reg_wdata[3]; m_ien = reg_wdata[6:4];
        m_sel0 = reg_wdata[27:20]; m_sel1 = reg_wdata[19:12];
      end
    end
  end

  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    expect_eq(cur_req, reg_rdata, m_read(reg_addr));
    expect_eq(cur_req, {31'd0, irq_out}, {31'd0, |(m_ovf & m_ien)});
  endtask

  task automatic step(logic [1:0] a, logic w, logic [31:0] d, logic [255:0] st);
    @(negedge clk);
    compare_now();
    reg_addr = a; reg_wr = w; reg_wdata = d; evt_strobe = st;
  endtask

  task automatic idle(int n, logic [255:0] st);
    for (int i = 0; i < n; i++) step(2'(i % 4), 1'b0, 32'd0, st);
  endtask

  function automatic logic [31:0] ctlw(bit en, bit dv, bit [2:0] ien,
      bit [7:0] s0, bit [7:0] s1, bit [2:0] clr, bit rev, bit rcy);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = rev; w[2] = rcy; w[3] = dv; w[6:4] = ien;
    w[10:8] = clr; w[27:20] = s0; w[19:12] = s1;
    return w;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [255:0] s5;
    s5 = '0; s5[5] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    cur_req = "R1";
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      expect_eq("R1", reg_rdata, 32'd0);
    end
    expect_eq("R1", {31'd0, irq_out}, 32'd0);
    // R2: disabled, strobes busy, selectors on cycle code
    cur_req = "R2";
    step(2'd0, 1'b1, ctlw(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0), '1);
    idle(12, '1);
    // R3 / R6: counter 0 on strobe 5, counter 1 on cycle code
    cur_req = "R3";
    step(2'd0, 1'b1, ctlw(1, 0, 0, 8'h05, 8'hFF, 0, 0, 0), '0);
    for (int i = 0; i < 20; i++) step(2'(2 + i % 2), 1'b0, 0, (i % 3 == 0) ? s5 : ~s5);
    // selectors swapped: counter 1 follows strobe 9, counter 0 idle code
    step(2'd0, 1'b1, ctlw(1, 0, 0, 8'h20, 8'h09, 0, 0, 0), '1);
    idle(10, '1);
    @(negedge clk); reg_addr = 2'd2; #1;
    cur_req = "R3";
    expect_eq("R3", reg_rdata, m_cnt[0]);
    cur_req = "R6";
    idle(8, rnd256());
    // R5 and R8/R10: preload near wrap
    cur_req = "R5";
    step(2'd0, 1'b1, ctlw(1, 0, 3'b010, 8'h20, 8'hFF, 0, 0, 0), '0);
    step(2'd3, 1'b1, 32'hFFFF_FFFD, '0);
    step(2'd3, 1'b0, 0, '0);
    cur_req = "R8";
    idle(4, '0);
    @(negedge clk); reg_addr = 2'd0; #1;
    expect_eq("R8", {31'd0, reg_rdata[9]}, 32'd1);
    expect_eq("R10", {31'd0, irq_out}, 32'd1);
    // R9: write 0 keeps, write 1 clears
    cur_req = "R9";
    step(2'd0, 1'b1, ctlw(1, 0, 3'b010, 8'h20, 8'h20, 3'b101, 0, 0), '0);
    step(2'd0, 1'b0, 0, '0);
    step(2'd0, 1'b1, ctlw(1, 0, 3'b010, 8'h20, 8'h20, 3'b010, 0, 0), '0);
    step(2'd0, 1'b0, 0, '0);
    @(negedge clk); #1;
    expect_eq("R9", {31'd0, irq_out}, 32'd0);
    // R9: clear in the same cycle as a wrap keeps flag
    step(2'd1, 1'b1, 32'hFFFF_FFFF, '0);
    step(2'd0, 1'b1, ctlw(1, 0, 3'b100, 8'h20, 8'h20, 3'b100, 0, 0), '0);
    cur_req = "R10";
    idle(4, '0);
    // R4: reset bits
    cur_req = "R4";
    step(2'd0, 1'b1, ctlw(1, 0, 0, 8'hFF, 8'hFF, 3'b111, 0, 0), '0);
    idle(6, '0);
    step(2'd0, 1'b1, ctlw(1, 0, 0, 8'hFF, 8'hFF, 0, 1, 0), '0);
    idle(4, '0);
    step(2'd0, 1'b1, ctlw(1, 0, 0, 8'hFF, 8'hFF, 0, 0, 1), '0);
    idle(4, '0);
    // R7: divided cycle rate
    cur_req = "R7";
    step(2'd0, 1'b1, ctlw(1, 1, 0, 8'h20, 8'h20, 0, 0, 1), '0);
    for (int i = 0; i < 200; i++) step(2'd1, 1'b0, 0, '0);
    @(negedge clk); reg_addr = 2'd1; #1;
    expect_eq("R7", reg_rdata, m_cnt[2]);
    // R11: control readback
    cur_req = "R11";
    step(2'd0, 1'b1, 32'hFFFF_FFF9 & ~32'h0000_0700, '0);
    step(2'd0, 1'b0, 0, '0);
    idle(3, '0);
    // mixed random traffic
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      d = $urandom;
      if (r < 4) d = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
      if (r < 10) step(2'($urandom_range(1, 3)), 1'b1, d, rnd256());
      else if (r < 16) begin
        d[1] = ($urandom_range(0, 7) == 0); d[2] = ($urandom_range(0, 7) == 0);
        d[0] = ($urandom_range(0, 4) != 0);
        step(2'd0, 1'b1, d, rnd256());
      end else step(2'($urandom_range(0, 3)), 1'b0, 0, rnd256());
    end
    idle(4, '0);
    finish_run();
  end
endmodule